// File: doc/BRIEF.md
# Instruction Stage Counter

This block holds the step number of a multi-step instruction. A sequencer reads the step number to choose which sub-instruction runs next. The value is a small counter. Several strobes from the control-pulse logic move it. Two strobes ask for a single stage bit to be set. These requests are not acted on at once. They are held until the end-of-cycle timing pulse arrives, and are then ORed into the count.

A divide-staging strobe moves the count one place along a fixed six-state order, 0, 1, 3, 7, 6, 4 and then back to 0. Each step complements the next bit position upward, so the counter behaves as a three-bit twisted-ring counter. A clear strobe returns the count to zero. A resume-test strobe compares an address input with the resume address (octal 0017 by default). It loads 3 when the address matches and 1 when it does not.

Top module: `stage_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the stage output becomes 0 and any held set requests are discarded.
- R2: A set request (set_b0 sets stage bit 0, set_b1 sets stage bit 1) does not change the stage until a cycle with end_pulse high; in that cycle's edge the requested bits are ORed into the stage.
- R3: Set requests given in different cycles before one end pulse are all held and are applied together at that end pulse.
- R4: Held requests are discarded once applied, so a later end pulse with no new request leaves the stage unchanged.
- R5: A set request raised in the same cycle as end_pulse is applied at that edge.
- R6: Each div_step moves the stage 0→1→3→7→6→4→0, i.e. the new value is {old[1:0], ~old[2]}.
- R7: clr_stage forces the stage to 0 and overrides every other strobe in the same cycle.
- R8: resume_test (without clr_stage) loads 3 when resume_addr equals octal 0017 and loads 1 otherwise.
- R9: Priority below clear is resume test, then divide step, then set-request apply. When end_pulse coincides with a higher-priority strobe, held requests are kept for the next end pulse.
- R10: With no strobe and no end_pulse, the stage holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| end_pulse | input | 1 | End-of-cycle timing pulse; held set requests apply here |
| set_b0 | input | 1 | Request to set stage bit 0 |
| set_b1 | input | 1 | Request to set stage bit 1 |
| div_step | input | 1 | Advance along the divide staging order |
| clr_stage | input | 1 | Force stage to zero |
| resume_test | input | 1 | Load 3 or 1 according to the resume address comparison |
| resume_addr | input | 12 | Address compared with the resume address |
| stage | output | 3 | Current stage value |

## Verification
The assertions treat the strobes as single-cycle levels sampled at the rising edge. They assume the resume address is stable for that edge. They allow any mix of strobes in one cycle, because the priority order defines the result of every mix. Each property is written for one slice of that order. For example, the divide-step property only applies when neither clear nor resume test is present. The stimulus drives every input one nanosecond after an edge and holds it for a full period. The stimulus deliberately sends strobes together in the same cycle, so that the priority order and the retention of held requests are exercised inside the assumed envelope.

// File: rtl/stage_ctl_pkg.sv
// Package: shared types and defaults for the instruction stage counter.
// Assumes: nothing; pure declarations.
package stage_ctl_pkg;
    localparam int STAGE_W_DEF = 3;
    localparam int ADDR_W_DEF  = 12;

    // Action chosen by the arbiter for one clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_CLEAR  = 3'd1,
        ACT_RESUME = 3'd2,
        ACT_DIVIDE = 3'd3,
        ACT_APPLY  = 3'd4
    } stage_act_e;
endpackage

// File: rtl/stage_req_latch.sv
// Module: holds stage-bit set requests until the end pulse consumes them.
// Assumes: 'consume' is asserted only in a cycle where the arbiter applies
// the requests; requests arriving in that same cycle are consumed with them.
module stage_req_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_b0,
    input  logic       set_b1,
    input  logic       consume,
    output logic [1:0] req_eff
);
    logic [1:0] held_q;

    // Effective request: what is held plus what arrives this cycle.
    always_comb req_eff = held_q | {set_b1, set_b0};

    // Latch requests; drop them once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (consume) held_q <= '0;
        else              held_q <= req_eff;
    end

    assert_req_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> held_q == 2'b00);
    assert_req_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && set_b1) |=> held_q[1]);
endmodule

// File: rtl/stage_div_step.sv
// Module: next value of the divide staging order (twisted ring).
// Assumes: WIDTH >= 2; for WIDTH 3 the order is 0,1,3,7,6,4.
module stage_div_step #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    // Shift up and feed the inverted top bit into bit 0.
    always_comb nxt = {cur[WIDTH-2:0], ~cur[WIDTH-1]};
endmodule

// File: rtl/stage_arbiter.sv
// Module: picks the one action for this edge and forms the next stage.
// Assumes: req_eff carries held plus new requests; priority is
// clear > resume > divide > apply-at-end-pulse > hold.
module stage_arbiter
    import stage_ctl_pkg::*;
#(
    parameter int STAGE_W = 3
) (
    input  logic [STAGE_W-1:0] cur,
    input  logic [STAGE_W-1:0] div_nxt,
    input  logic [1:0]         req_eff,
    input  logic               end_pulse,
    input  logic               div_step,
    input  logic               clr_stage,
    input  logic               resume_test,
    input  logic               addr_match,
    output logic [STAGE_W-1:0] nxt,
    output logic               consume
);
    localparam logic [STAGE_W-1:0] LOAD_HIT  = STAGE_W'(3);
    localparam logic [STAGE_W-1:0] LOAD_MISS = STAGE_W'(1);

    stage_act_e act;

    // Choose the action by fixed priority.
    always_comb begin
        if (clr_stage)        act = ACT_CLEAR;
        else if (resume_test) act = ACT_RESUME;
        else if (div_step)    act = ACT_DIVIDE;
        else if (end_pulse)   act = ACT_APPLY;
        else                  act = ACT_HOLD;
    end

    // Form next stage value for the chosen action.
    always_comb begin
        unique case (act)
            ACT_CLEAR:  nxt = '0;
            ACT_RESUME: nxt = addr_match ? LOAD_HIT : LOAD_MISS;
            ACT_DIVIDE: nxt = div_nxt;
            ACT_APPLY:  nxt = cur | STAGE_W'(req_eff);
            default:    nxt = cur;
        endcase
    end

    // Requests are used up only when actually applied.
    always_comb consume = (act == ACT_APPLY);
endmodule

// File: rtl/stage_counter.sv
// Module: top of the instruction stage counter.
// Assumes: strobes are one-cycle levels sampled at the rising edge;
// synchronous active-low reset; STAGE_W >= 2.
module stage_counter
    import stage_ctl_pkg::*;
#(
    parameter int STAGE_W = STAGE_W_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] RESUME_ADDR = ADDR_W'('o17)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_pulse,
    input  logic              set_b0,
    input  logic              set_b1,
    input  logic              div_step,
    input  logic              clr_stage,
    input  logic              resume_test,
    input  logic [ADDR_W-1:0] resume_addr,
    output logic [STAGE_W-1:0] stage
);
    logic [STAGE_W-1:0] stage_q;
    logic [STAGE_W-1:0] div_nxt;
    logic [STAGE_W-1:0] stage_d;
    logic [1:0]         req_eff;
    logic               consume;
    logic               addr_match;

    // Resume address comparison.
    always_comb addr_match = (resume_addr == RESUME_ADDR);

    stage_req_latch i_req (
        .clk(clk), .rst_n(rst_n), .set_b0(set_b0), .set_b1(set_b1),
        .consume(consume), .req_eff(req_eff)
    );

    stage_div_step #(.WIDTH(STAGE_W)) i_div (
        .cur(stage_q), .nxt(div_nxt)
    );

    stage_arbiter #(.STAGE_W(STAGE_W)) i_arb (
        .cur(stage_q), .div_nxt(div_nxt), .req_eff(req_eff),
        .end_pulse(end_pulse), .div_step(div_step), .clr_stage(clr_stage),
        .resume_test(resume_test), .addr_match(addr_match),
        .nxt(stage_d), .consume(consume)
    );

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    always_comb stage = stage_q;

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stage |=> stage == '0);
    assert_resume_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_test && !clr_stage) |=>
            stage == (($past(resume_addr) == RESUME_ADDR) ? STAGE_W'(3) : STAGE_W'(1)));
    assert_div_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_step && !clr_stage && !resume_test) |=>
            stage == {$past(stage[STAGE_W-2:0]), ~$past(stage[STAGE_W-1])});
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_pulse && !div_step && !clr_stage && !resume_test) |=> $stable(stage));
    assert_apply_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_pulse && set_b1 && !div_step && !clr_stage && !resume_test) |=> stage[1]);
endmodule

// File: tb/test_stage_counter.sv
module test_stage_counter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        end_pulse, set_b0, set_b1, div_step, clr_stage, resume_test;
    logic [11:0] resume_addr;
    logic [2:0]  stage;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    stage_counter i_stage_counter (
        .clk(clk), .rst_n(rst_n), .end_pulse(end_pulse), .set_b0(set_b0),
        .set_b1(set_b1), .div_step(div_step), .clr_stage(clr_stage),
        .resume_test(resume_test), .resume_addr(resume_addr), .stage(stage)
    );

    // Row: [24:21] req, [20] b0, [19] b1, [18] end, [17] div, [16] clr,
    // [15] resume, [14:3] addr, [2:0] expected stage after the edge.
    function automatic logic [24:0] mk(int r, bit b0, bit b1, bit ep, bit dv,
                                       bit cl, bit rs, int addr, int ex);
        return {4'(r), b0, b1, ep, dv, cl, rs, 12'(addr), 3'(ex)};
    endfunction

    localparam int NV = 29;
    localparam logic [24:0] VEC [NV] = '{
        mk(6,0,0,0,1,0,0,0,1),      // R6 0->1
        mk(6,0,0,0,1,0,0,0,3),      // R6 1->3
        mk(6,0,0,0,1,0,0,0,7),      // R6 3->7
        mk(6,0,0,0,1,0,0,0,6),      // R6 7->6
        mk(6,0,0,0,1,0,0,0,4),      // R6 6->4
        mk(6,0,0,0,1,0,0,0,0),      // R6 4->0
        mk(2,1,0,0,0,0,0,0,0),      // R2 request waits
        mk(10,0,0,0,0,0,0,0,0),     // R10 idle
        mk(2,0,0,1,0,0,0,0,1),      // R2 applied at end pulse
        mk(4,0,0,1,0,0,0,0,1),      // R4
        mk(7,0,0,0,0,1,0,0,0),      // R7
        mk(4,0,0,1,0,0,0,0,0),      // R4 nothing left held
        mk(3,0,1,0,0,0,0,0,0),      // R3
        mk(3,1,0,0,0,0,0,0,0),      // R3
        mk(3,0,0,1,0,0,0,0,3),      // R3 both applied
        mk(7,0,0,0,0,1,0,0,0),      // R7
        mk(5,0,1,1,0,0,0,0,2),      // R5 same-cycle request
        mk(8,0,0,0,0,0,1,'o17,3),   // R8 match
        mk(8,0,0,0,0,0,1,'o16,1),   // R8 miss
        mk(7,1,0,1,1,1,1,'o17,0),   // R7 clear beats all
        mk(9,0,0,1,0,0,0,0,1),      // R9 request kept through clear
        mk(7,0,0,0,0,1,0,0,0),      // R7
        mk(9,0,1,0,0,0,0,0,0),      // R9
        mk(9,0,0,1,1,0,0,0,1),      // R9 divide beats apply
        mk(9,0,0,1,0,0,0,0,3),      // R9 held request survives
        mk(7,0,0,0,0,1,0,0,0),      // R7
        mk(9,0,0,0,1,0,1,'o17,3),   // R9 resume beats divide
        mk(10,0,0,0,0,0,0,0,3),     // R10 idle
        mk(6,0,0,0,1,0,0,0,7)       // R6 3->7
    };

    task automatic check(input string tag, input logic [2:0] exp);
        n_chk++;
        if (stage !== exp) begin
            n_bad++;
            $display("FAIL %s: stage=%0d expected=%0d", tag, stage, exp);
        end
    endtask

    task automatic idle_inputs();
        end_pulse = 0; set_b0 = 0; set_b1 = 0; div_step = 0;
        clr_stage = 0; resume_test = 0; resume_addr = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: stage=%0d expected=done", stage);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        tick(); tick();
        check("R1 reset state", 3'd0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            set_b0      = VEC[i][20];
            set_b1      = VEC[i][19];
            end_pulse   = VEC[i][18];
            div_step    = VEC[i][17];
            clr_stage   = VEC[i][16];
            resume_test = VEC[i][15];
            resume_addr = VEC[i][14:3];
            tick();
            idle_inputs();
            check($sformatf("R%0d row %0d", VEC[i][24:21], i), VEC[i][2:0]);
        end

        // R1: reset with a held request discards both stage and request.
        clr_stage = 1; tick(); idle_inputs();
        div_step = 1; tick(); idle_inputs();
        set_b1 = 1; tick(); idle_inputs();
        check("R1 setup", 3'd1);
        rst_n = 0; tick(); rst_n = 1;
        check("R1 reset mid-run", 3'd0);
        end_pulse = 1; tick(); idle_inputs();
        check("R1 held request dropped", 3'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule